// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

This block gathers many level-sensitive interrupt lines and folds them into a smaller set of group outputs for a parent interrupt controller. Each group has eight sources and drives one output line. The output is high when any enabled source in its group is high. Four groups share one 32-bit register bank. Group j of a bank owns byte j of each register in that bank. The number of banks is a parameter, and the banks sit 0x10 bytes apart in the address map.

Software never writes an enable mask directly. It changes enables only through two registers. One sets every enable bit that is written as 1. The other clears every enable bit that is written as 1. Bits written as 0 are left alone in both cases, so two agents can change different sources without a read-modify-write sequence. A read-only status register shows each source's input ANDed with its enable, live and unlatched. Each group output is this status, ORed over the group's byte and registered once.

Top module: `irq_group_combiner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every enable bit is 0. Every group output is low, and the status register of every bank reads zero.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1. Every enable bit whose write-data bit is 0 keeps its value.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1. Every enable bit whose write-data bit is 0 keeps its value.
- R4: A read of bank offset 0xC returns the bitwise AND of that bank's 32 source inputs and its 32 enable bits, in the same cycle. A write to offset 0xC changes no enable bit.
- R5: A read of bank offset 0x0 or 0x4 returns that bank's current 32 enable bits.
- R6: The following locations read as zero, and a write to any of them changes no enable bit: offset 0x8, any offset whose two low address bits are not 00, and any bank index (address bits above bit 3) of NUM_BANKS or more.
- R7: Bank b starts at byte address 0x10*b. Source n is input `src_i[n]` and belongs to group n/8. Group g uses bits [8*(g mod 4)+7 : 8*(g mod 4)] of bank g/4, and its output is `grp_irq_o[g]`.
- R8: `grp_irq_o[g]` equals, one clock edge later, the OR of group g's status bits.
- R9: Sources are level-sensitive. A status bit follows its input as soon as the input changes, and returns to 0 when the input falls, with no latching and no write-to-clear action.
- R10: An enable change made by a write shows in the status register from the cycle after the write's clock edge. It shows in the group output one cycle after that, because the output is computed from the enables that were in place before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Level interrupt sources, bit n is source n |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_wr_i | input | 1 | Write strobe, applied at the clock edge |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| grp_irq_o | output | NUM_BANKS*4 | Registered group interrupt outputs |

## Verification
The interaction that needs care is an enable write in the same cycle that a group output is computed. The output registered at that edge still uses the old enables, while the status register reads the new ones immediately afterwards. The bench provokes this by clearing, and later setting, an enable while its source is held high. It then checks that the status read and the group output disagree for exactly one cycle and that both then settle. A random phase mixes set and clear writes with source changes, and with accesses to reserved and out-of-range addresses, on every cycle. Each result is judged against a behavioural model that updates its group outputs from the enables it held before applying the write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned WORD_W        = 32;
    localparam int unsigned GRP_SRC       = 8;
    localparam int unsigned GRPS_PER_BANK = WORD_W / GRP_SRC;

    // Register offsets inside one 0x10-byte bank
    localparam logic [3:0] OFF_SET  = 4'h0;
    localparam logic [3:0] OFF_CLR  = 4'h4;
    localparam logic [3:0] OFF_STAT = 4'hC;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_STAT = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0]        en;
        logic [GRPS_PER_BANK-1:0] grp;
    } bank_state_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [BIDX_W-1:0] bank_o
);

    logic [ADDR_W-5:0] bank_field;
    logic [3:0]        offset;
    logic              in_range;

    assign bank_field = addr_i[ADDR_W-1:4];
    assign offset     = addr_i[3:0];
    assign in_range   = (int'(bank_field) < int'(NUM_BANKS));
    assign bank_o     = BIDX_W'(bank_field);

    always_comb begin
        kind_o = REG_NONE;
        if (in_range) begin
            unique case (offset)
                OFF_SET:  kind_o = REG_SET;
                OFF_CLR:  kind_o = REG_CLR;
                OFF_STAT: kind_o = REG_STAT;
                default:  kind_o = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [WORD_W-1:0]        src_i,
    input  logic                     set_i,
    input  logic                     clr_i,
    input  logic [WORD_W-1:0]        wdata_i,
    output logic [WORD_W-1:0]        en_o,
    output logic [WORD_W-1:0]        stat_o,
    output logic [GRPS_PER_BANK-1:0] grp_o
);

    bank_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        stat_o = src_i & st_q.en;
        if (set_i) begin
            st_d.en = st_d.en | wdata_i;
        end
        if (clr_i) begin
            st_d.en = st_d.en & ~wdata_i;
        end
        for (int j = 0; j < int'(GRPS_PER_BANK); j++) begin
            st_d.grp[j] = |stat_o[j*GRP_SRC +: GRP_SRC];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign grp_o = st_q.grp;

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned NUM_GRP  = NUM_BANKS * GRPS_PER_BANK,
    localparam int unsigned NUM_SRC  = NUM_GRP * GRP_SRC
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    input  logic               reg_wr_i,
    output logic [31:0]        reg_rdata_o,
    output logic [NUM_GRP-1:0] grp_irq_o
);

    localparam int unsigned BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    reg_kind_e                           kind;
    logic [BIDX_W-1:0]                   bank_idx;
    logic [NUM_BANKS-1:0][WORD_W-1:0]    bank_en;
    logic [NUM_BANKS-1:0][WORD_W-1:0]    bank_stat;
    logic [NUM_SRC-1:0]                  en_all;

    irqc_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) decode_i (
        .addr_i (reg_addr_i),
        .kind_o (kind),
        .bank_o (bank_idx)
    );

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
        logic hit;
        assign hit = reg_wr_i && (bank_idx == BIDX_W'(b));

        irqc_bank bank_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .src_i   (src_i[b*WORD_W +: WORD_W]),
            .set_i   (hit && (kind == REG_SET)),
            .clr_i   (hit && (kind == REG_CLR)),
            .wdata_i (reg_wdata_i),
            .en_o    (bank_en[b]),
            .stat_o  (bank_stat[b]),
            .grp_o   (grp_irq_o[b*GRPS_PER_BANK +: GRPS_PER_BANK])
        );

        assign en_all[b*WORD_W +: WORD_W] = bank_en[b];
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (bank_idx == BIDX_W'(b)) begin
                unique case (kind)
                    REG_SET, REG_CLR: reg_rdata_o = bank_en[b];
                    REG_STAT:         reg_rdata_o = bank_stat[b];
                    default:          reg_rdata_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned NUM_GRP  = NUM_BANKS * 4,
    localparam int unsigned NUM_SRC  = NUM_GRP * 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [31:0]        reg_wdata_i,
    input logic               reg_wr_i,
    input logic [31:0]        reg_rdata_o,
    input logic [NUM_GRP-1:0] grp_irq_o,
    input logic [NUM_SRC-1:0] en_all
);

    logic               in_rng;
    logic [3:0]         off;
    int                 bank_c;
    int                 bank_q;
    logic [31:0]        en_at_q;
    logic [31:0]        live_stat;
    logic [NUM_GRP-1:0] grp_exp;

    assign off    = reg_addr_i[3:0];
    assign in_rng = int'(reg_addr_i[ADDR_W-1:4]) < int'(NUM_BANKS);
    assign bank_c = in_rng ? int'(reg_addr_i[ADDR_W-1:4]) : 0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= 0;
        else         bank_q <= bank_c;
    end

    assign en_at_q   = en_all[bank_q*32 +: 32];
    assign live_stat = src_i[bank_c*32 +: 32] & en_all[bank_c*32 +: 32];

    always_comb begin
        for (int g = 0; g < int'(NUM_GRP); g++) begin
            grp_exp[g] = |(src_i[g*8 +: 8] & en_all[g*8 +: 8]);
        end
    end

    p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (en_all == '0 && grp_irq_o == '0));

    p_set_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && in_rng && off == 4'h0) |=>
            ((en_at_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));

    p_clr_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && in_rng && off == 4'h4) |=>
            ((en_at_q & $past(reg_wdata_i)) == 32'h0));

    p_stat_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_rng && off == 4'hC) |-> (reg_rdata_o == live_stat));

    p_reserved_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_rng || off == 4'h8 || off[1:0] != 2'b00) |-> (reg_rdata_o == 32'h0));

    p_no_silent_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reg_wr_i || !in_rng || off == 4'h8 || off == 4'hC || off[1:0] != 2'b00)
            |=> $stable(en_all));

    p_grp_registered_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grp_irq_o == $past(grp_exp));

endmodule

bind irq_group_combiner irqc_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rdata_o (reg_rdata_o),
    .grp_irq_o   (grp_irq_o),
    .en_all      (en_all)
);

// File: tb/irq_group_combiner_tb_top.sv
`timescale 1ns/1ps
module irq_group_combiner_tb_top;

    localparam int NB   = 2;
    localparam int AW   = 8;
    localparam int NG   = NB * 4;
    localparam int NS   = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          wr = 1'b0;
    logic [31:0]   rdata;
    logic [NG-1:0] grp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_group_combiner #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_wr_i    (wr),
        .reg_rdata_o (rdata),
        .grp_irq_o   (grp)
    );

    // ---------------- behavioural reference ----------------
    logic [NS-1:0] m_en;
    logic [NG-1:0] m_grp;
    logic [NS-1:0] m_tmp;

    function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
        int bank = int'(a) / 16;
        int off  = int'(a) % 16;
        if (bank >= NB) return 32'h0;
        if (off == 0 || off == 4) return m_en[bank*32 +: 32];
        if (off == 12) return src[bank*32 +: 32] & m_en[bank*32 +: 32];
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en  <= '0;
            m_grp <= '0;
        end else begin
            for (int g = 0; g < NG; g++) begin
                m_grp[g] <= |(src[g*8 +: 8] & m_en[g*8 +: 8]);
            end
            m_tmp = m_en;
            if (wr && (int'(addr) / 16) < NB) begin
                if (int'(addr) % 16 == 0)
                    m_tmp[(int'(addr)/16)*32 +: 32] = m_tmp[(int'(addr)/16)*32 +: 32] | wdata;
                else if (int'(addr) % 16 == 4)
                    m_tmp[(int'(addr)/16)*32 +: 32] = m_tmp[(int'(addr)/16)*32 +: 32] & ~wdata;
            end
            m_en <= m_tmp;
        end
    end

    // ---------------- checking ----------------
    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [AW-1:0] a, input logic [31:0] d, input logic w,
                        input logic [NS-1:0] s, input string tag);
        @(negedge clk);
        addr = a; wdata = d; wr = w; src = s;
        #1;
        check32(tag, rdata, model_rd(a));
        check32("R8", 32'(grp), 32'(m_grp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [NS-1:0] s;
        // R1: reset state
        for (int i = 0; i < 3; i++) step(8'h0C, 32'hFFFF_FFFF, 1'b1, '1, "R1");
        @(negedge clk); rst_n = 1'b1;
        step(8'h0C, 32'h0, 1'b0, '1, "R1");
        step(8'h1C, 32'h0, 1'b0, '1, "R1");

        // R2 / R5: set register, zeros leave bits alone
        step(8'h00, 32'h0000_00FF, 1'b1, '0, "R2");
        step(8'h00, 32'h0000_0100, 1'b1, '0, "R2");
        step(8'h00, 32'h0, 1'b0, '0, "R5");
        step(8'h04, 32'h0, 1'b0, '0, "R5");

        // R3: clear register
        step(8'h04, 32'h0000_0001, 1'b1, '0, "R3");
        step(8'h04, 32'h0, 1'b0, '0, "R3");
        step(8'h04, 32'h0, 1'b1, '0, "R3");
        step(8'h00, 32'h0, 1'b0, '0, "R3");

        // R4 / R9: status follows live inputs, write ignored
        s = '0; s[3:0] = 4'hF; s[8] = 1'b1;
        step(8'h0C, 32'h0, 1'b0, s, "R4");
        step(8'h0C, 32'hFFFF_FFFF, 1'b1, s, "R4");
        step(8'h00, 32'h0, 1'b0, s, "R4");
        s[3:0] = 4'h0;
        step(8'h0C, 32'h0, 1'b0, s, "R9");
        step(8'h0C, 32'h0, 1'b0, '0, "R9");
        step(8'h0C, 32'h0, 1'b0, '0, "R9");

        // R6: reserved, misaligned and out-of-range locations
        step(8'h08, 32'hFFFF_FFFF, 1'b1, '1, "R6");
        step(8'h01, 32'hFFFF_FFFF, 1'b1, '1, "R6");
        step(8'h25, 32'hFFFF_FFFF, 1'b1, '1, "R6");
        step(8'h20, 32'hFFFF_FFFF, 1'b1, '1, "R6");
        step(8'h34, 32'hFFFF_FFFF, 1'b1, '1, "R6");
        step(8'hFC, 32'h0, 1'b0, '1, "R6");
        step(8'h00, 32'h0, 1'b0, '1, "R6");
        step(8'h10, 32'h0, 1'b0, '1, "R6");

        // R7: second bank, top group, top source
        s = '0; s[NS-1] = 1'b1;
        step(8'h10, 32'hFF00_0000, 1'b1, s, "R7");
        step(8'h1C, 32'h0, 1'b0, s, "R7");
        step(8'h1C, 32'h0, 1'b0, s, "R7");
        step(8'h04, 32'hFFFF_FFFF, 1'b1, s, "R7");
        step(8'h14, 32'hFFFF_FFFF, 1'b1, s, "R7");
        step(8'h1C, 32'h0, 1'b0, s, "R7");
        step(8'h1C, 32'h0, 1'b0, s, "R7");

        // R10: enable change against a held-high source
        s = '0; s[16] = 1'b1;
        step(8'h00, 32'h0001_0000, 1'b1, s, "R10");
        step(8'h0C, 32'h0, 1'b0, s, "R10");
        step(8'h0C, 32'h0, 1'b0, s, "R10");
        step(8'h04, 32'h0001_0000, 1'b1, s, "R10");
        step(8'h0C, 32'h0, 1'b0, s, "R10");
        step(8'h0C, 32'h0, 1'b0, s, "R10");
        step(8'h0C, 32'h0, 1'b0, s, "R10");

        // random mix of all functions
        s = '0;
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            int            pick;
            pick = int'($urandom_range(0, 9));
            a[7:4] = 4'($urandom_range(0, 3));
            case (pick)
                0, 1, 2: a[3:0] = 4'h0;
                3, 4, 5: a[3:0] = 4'h4;
                6, 7:    a[3:0] = 4'hC;
                8:       a[3:0] = 4'h8;
                default: a[3:0] = 4'($urandom_range(0, 15));
            endcase
            d = $urandom() & $urandom();
            if ($urandom_range(0, 3) == 0) s = {$urandom(), $urandom()};
            step(a, d, 1'($urandom_range(0, 1)), s, "R9");
        end

        finish_run();
    end

endmodule